// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the programming state for a frequency synthesizer: a 9-bit feedback divide value (M) and a 3-bit output divide code (N). Values arrive by one of two routes. On the parallel route they come from dedicated M and N pins and are captured when a parallel strobe rises. On the serial route a 12-bit word is shifted in one bit per serial clock and is moved into the divider registers when a serial strobe rises. When neither strobe is high, the pins pass straight to the active outputs.

All control inputs are sampled on one system clock. Edges of the strobes and of the serial clock are detected between consecutive samples. A reset edge counts as a low sample, so an input already high in the first cycle after reset is seen as a rising edge. The active M and N values, the decoded output divide ratio and a test output are registered. They change on the clock edge that samples the causing input. An out-of-range flag on the active M value helps checking. The out-of-range value is still applied.

Top module: `synth_div_loader`

## Requirements
- R1: When `rst` is high at a clock edge, all registered outputs are zero after that edge, and the shift register and the latched M/N registers are cleared. After reset, a serial strobe that is already high loads the cleared shift register, giving M = 0 and N code 0.
- R2: At an edge where `pload` and `sload` are both low, `m_active` and `n_active` take the values on `m_pins` and `n_pins`, and `test_out` goes low.
- R3: A rising `pload` sampled while `sload` is low captures the pins into the latched registers. While `pload` stays high, the active outputs hold the captured values whatever the pins do.
- R4: While `sload` is low, each sampled rising edge of `sclk` shifts `sdata` into bit 0 of a 12-bit shift register, so the word is sent MSB first. After 12 shifts, bits 11:9 hold the N code and bits 8:0 hold M. Bits shifted in earlier are discarded.
- R5: A rising `sload` copies the shift register into the latched M and N registers. The active outputs show the copied values after that same edge.
- R6: While `sload` remains high after its rising edge, the active M and N hold. Pins, `pload` edges and `sclk` edges change neither them nor the shift register.
- R7: While `sload` is high, each rising `sclk` copies `sdata` to `test_out`; this includes the edge on which `sload` rises. At any edge with `sload` low, `test_out` becomes low.
- R8: `div_ratio` is one-hot and gives the output divide ratio. N codes 000, 001, 010 and 011 give 2, 4, 8 and 16. Codes 100, 101, 110 and 111 give 1, 2, 4 and 8.
- R9: `m_out_of_range` is high exactly when `m_active` is below 125 or above 350. The value is still presented.
- R10: A rising `sload` takes priority over a rising `pload` and over an `sclk` edge in the same cycle. The transfer uses the shift register contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| m_pins | input | 9 | Parallel M value |
| n_pins | input | 3 | Parallel N code |
| pload | input | 1 | Parallel load strobe |
| sclk | input | 1 | Serial shift clock (sampled) |
| sload | input | 1 | Serial load strobe |
| sdata | input | 1 | Serial data bit |
| m_active | output | 9 | Active feedback divide value |
| n_active | output | 3 | Active output divide code |
| div_ratio | output | 5 | One-hot output divide ratio (1 to 16) |
| test_out | output | 1 | Serial test path output |
| m_out_of_range | output | 1 | Active M is outside 125..350 |

## Verification
The serial strobe, the parallel strobe and the serial clock can all rise in one sampled cycle. The transfer, the parallel capture and a shift then compete for the same registers. The bench raises all three on one clock after a full serial word has been shifted. It expects the active values to equal that word, not the pins and not a word shifted one place further. It also expects `test_out` to carry the data bit that came with the coinciding clock edge.

// File: rtl/synth_div_loader_pkg.sv
package synth_div_loader_pkg;

    localparam int M_W   = 9;
    localparam int N_W   = 3;
    localparam int SR_W  = M_W + N_W;
    localparam int DIV_W = (1 << (N_W - 1)) + 1;
    localparam int M_MIN = 125;
    localparam int M_MAX = 350;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } div_cfg_t;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_PARLAT = 2'd1,
        MODE_SERLAT = 2'd2
    } load_mode_t;

    // Lower half of the code space divides by 2..16, upper half by 1..8.
    function automatic logic [DIV_W-1:0] ratio_of(input logic [N_W-1:0] code);
        logic [N_W-2:0] sh;
        sh = code[N_W-2:0];
        if (code[N_W-1])
            return DIV_W'(1) << sh;
        else
            return DIV_W'(2) << sh;
    endfunction

    function automatic logic m_ok(input logic [M_W-1:0] m);
        return (m >= M_W'(M_MIN)) && (m <= M_W'(M_MAX));
    endfunction

endpackage

// File: rtl/synth_div_loader_edge.sv
module synth_div_loader_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/synth_div_loader_shift.sv
module synth_div_loader_shift #(
    parameter int LEN = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= {q[LEN-2:0], din};
    end
endmodule

// File: rtl/synth_div_loader_hold.sv
module synth_div_loader_hold
    import synth_div_loader_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t pin_cfg,
    input  div_cfg_t sr_cfg,
    input  logic     sload,
    input  logic     sload_rise,
    input  logic     pload_rise,
    output div_cfg_t lat_next
);
    div_cfg_t lat_q;

    always_comb begin
        lat_next = lat_q;
        if (sload_rise)
            lat_next = sr_cfg;
        else if (!sload && pload_rise)
            lat_next = pin_cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_next;
    end
endmodule

// File: rtl/synth_div_loader.sv
module synth_div_loader
    import synth_div_loader_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [M_W-1:0]   m_pins,
    input  logic [N_W-1:0]   n_pins,
    input  logic             pload,
    input  logic             sclk,
    input  logic             sload,
    input  logic             sdata,
    output logic [M_W-1:0]   m_active,
    output logic [N_W-1:0]   n_active,
    output logic [DIV_W-1:0] div_ratio,
    output logic             test_out,
    output logic             m_out_of_range
);
    localparam int EDGES = 3;

    logic [EDGES-1:0] rise;
    logic             pload_rise, sclk_rise, sload_rise;
    logic [SR_W-1:0]  sr_q;
    div_cfg_t         pin_cfg, sr_cfg, lat_next, act_next, act_q;
    load_mode_t       mode;
    logic [DIV_W-1:0] div_q;
    logic             test_q;

    synth_div_loader_edge #(.W(EDGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({sload, sclk, pload}),
        .rise (rise)
    );
    assign pload_rise = rise[0];
    assign sclk_rise  = rise[1];
    assign sload_rise = rise[2];

    synth_div_loader_shift #(.LEN(SR_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise && !sload),
        .din      (sdata),
        .q        (sr_q)
    );

    assign pin_cfg = '{n: n_pins, m: m_pins};
    assign sr_cfg  = div_cfg_t'(sr_q);

    synth_div_loader_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .pin_cfg    (pin_cfg),
        .sr_cfg     (sr_cfg),
        .sload      (sload),
        .sload_rise (sload_rise),
        .pload_rise (pload_rise),
        .lat_next   (lat_next)
    );

    always_comb begin
        if (sload)      mode = MODE_SERLAT;
        else if (pload) mode = MODE_PARLAT;
        else            mode = MODE_PASS;
    end

    assign act_next = (mode == MODE_PASS) ? pin_cfg : lat_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            div_q  <= '0;
            test_q <= 1'b0;
        end else begin
            act_q <= act_next;
            div_q <= ratio_of(act_next.n);
            if (mode != MODE_SERLAT) test_q <= 1'b0;
            else if (sclk_rise)      test_q <= sdata;
        end
    end

    assign m_active       = act_q.m;
    assign n_active       = act_q.n;
    assign div_ratio      = div_q;
    assign test_out       = test_q;
    assign m_out_of_range = !m_ok(act_q.m);
endmodule

// File: rtl/synth_div_loader_chk.sv
module synth_div_loader_chk
    import synth_div_loader_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [M_W-1:0]   m_pins,
    input logic [N_W-1:0]   n_pins,
    input logic             pload,
    input logic             sload,
    input logic [M_W-1:0]   m_active,
    input logic [N_W-1:0]   n_active,
    input logic [DIV_W-1:0] div_ratio,
    input logic             test_out
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: outputs are zero after a reset edge
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_zero_r1: assert (m_active == '0 && n_active == '0 &&
                                     div_ratio == '0 && test_out == 1'b0);
        end
    end

    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (!pload && !sload) |=> (m_active == $past(m_pins) &&
                                n_active == $past(n_pins) && !test_out));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(sload) && $past(sload, 2) && !$past(rst) && !$past(rst, 2))
        |-> (m_active == $past(m_active) && n_active == $past(n_active)));

    p_test_low_r7: assert property (@(posedge clk) disable iff (rst)
        !sload |=> !test_out);

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        !rst_q |-> $onehot(div_ratio));

    p_low_bank_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && !n_active[N_W-1]) |-> (div_ratio > DIV_W'(1)));
endmodule

bind synth_div_loader synth_div_loader_chk u_chk (.*);

// File: tb/synth_div_loader_tb.sv
module synth_div_loader_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] m_pins = '0;
    logic [2:0] n_pins = '0;
    logic       pload = 1'b0, sclk = 1'b0, sload = 1'b0, sdata = 1'b0;
    logic [8:0] m_active;
    logic [2:0] n_active;
    logic [4:0] div_ratio;
    logic       test_out, m_out_of_range;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    synth_div_loader u_dut (
        .clk(clk), .rst(rst), .m_pins(m_pins), .n_pins(n_pins),
        .pload(pload), .sclk(sclk), .sload(sload), .sdata(sdata),
        .m_active(m_active), .n_active(n_active), .div_ratio(div_ratio),
        .test_out(test_out), .m_out_of_range(m_out_of_range)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input logic [2:0] code);
        case (code)
            3'b000: return 2;   3'b001: return 4;
            3'b010: return 8;   3'b011: return 16;
            3'b100: return 1;   3'b101: return 2;
            3'b110: return 4;   default: return 8;
        endcase
    endfunction

    task automatic shift_bit(input logic b);
        sdata = b; sclk = 1'b1; tick();
        sclk = 1'b0; tick();
    endtask

    task automatic shift_word(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic t_reset();
        m_pins = 9'd300; n_pins = 3'd3; rst = 1'b1;
        tick(); tick();
        chk("R1 m after reset", m_active, 0);
        chk("R1 n after reset", n_active, 0);
        chk("R1 ratio after reset", div_ratio, 0);
        chk("R1 test after reset", test_out, 0);
        chk("R9 flag for M=0", m_out_of_range, 1);
        rst = 1'b0;
    endtask

    task automatic t_pass();
        m_pins = 9'd200; n_pins = 3'd3; tick();
        chk("R2 pass m", m_active, 200);
        chk("R2 pass n", n_active, 3);
        chk("R8 ratio code 3", div_ratio, 16);
        chk("R2 test low", test_out, 0);
        m_pins = 9'd210; n_pins = 3'd4; tick();
        chk("R2 pass m follows", m_active, 210);
        chk("R8 ratio code 4", div_ratio, 1);
    endtask

    task automatic t_range();
        int vals [6] = '{124, 125, 350, 351, 0, 511};
        int flags[6] = '{1, 0, 0, 1, 1, 1};
        for (int i = 0; i < 6; i++) begin
            m_pins = 9'(vals[i]); tick();
            chk("R9 value applied", m_active, vals[i]);
            chk("R9 range flag", m_out_of_range, flags[i]);
        end
    endtask

    task automatic t_decode();
        for (int c = 0; c < 8; c++) begin
            n_pins = 3'(c); tick();
            chk("R8 ratio decode", div_ratio, exp_ratio(3'(c)));
        end
    endtask

    task automatic t_parallel();
        m_pins = 9'd300; n_pins = 3'd1; pload = 1'b1; tick();
        chk("R3 capture m", m_active, 300);
        chk("R3 capture ratio", div_ratio, 4);
        m_pins = 9'd130; n_pins = 3'd5; tick(); tick();
        chk("R3 hold m", m_active, 300);
        chk("R3 hold n", n_active, 1);
        pload = 1'b0; tick();
        chk("R2 release m", m_active, 130);
        chk("R8 ratio code 5", div_ratio, 2);
    endtask

    task automatic t_serial();
        m_pins = 9'd140; n_pins = 3'd0;
        shift_bit(1'b1);                 // extra leading bit must fall off
        shift_word({3'b110, 9'd250});
        chk("R2 pins while shifting", m_active, 140);
        sload = 1'b1; tick();
        chk("R5 transfer m", m_active, 250);
        chk("R5 transfer n", n_active, 6);
        chk("R4 msb first ratio", div_ratio, 4);
        sdata = 1'b1; sclk = 1'b1; tick();
        chk("R7 test copies 1", test_out, 1);
        chk("R6 sclk no effect", m_active, 250);
        sclk = 1'b0; tick();
        sdata = 1'b0; sclk = 1'b1; tick();
        chk("R7 test copies 0", test_out, 0);
        sclk = 1'b0; sdata = 1'b1; tick();
        m_pins = 9'd333; n_pins = 3'd2; pload = 1'b1; tick();
        chk("R6 pins and pload ignored m", m_active, 250);
        chk("R6 pins and pload ignored n", n_active, 6);
        pload = 1'b0; sload = 1'b0; tick();
        chk("R7 test low after sload falls", test_out, 0);
        chk("R2 pass after serial", m_active, 333);
        sload = 1'b1; tick();
        chk("R6 shift register untouched", m_active, 250);
        sload = 1'b0; tick();
    endtask

    task automatic t_collide();
        shift_word({3'b010, 9'd180});
        m_pins = 9'd300; n_pins = 3'd0;
        sload = 1'b1; pload = 1'b1; sclk = 1'b1; sdata = 1'b1; tick();
        chk("R10 serial wins m", m_active, 180);
        chk("R10 serial wins n", n_active, 2);
        chk("R10 ratio", div_ratio, 8);
        chk("R7 test on coinciding edge", test_out, 1);
        sclk = 1'b0; pload = 1'b0; tick();
        chk("R10 no late shift", m_active, 180);
    endtask

    task automatic t_reset_clears();
        rst = 1'b1; tick();
        chk("R1 reset during sload", m_active, 0);
        rst = 1'b0; tick();
        chk("R1 cleared shift register m", m_active, 0);
        chk("R1 cleared shift register n", n_active, 0);
        chk("R9 flag after cleared load", m_out_of_range, 1);
        sload = 1'b0; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_pass();
        t_range();
        t_decode();
        t_parallel();
        t_serial();
        t_collide();
        t_reset_clears();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule